// File: doc/BRIEF.md
# Ordered Bus Fence Sequencer

This block closes and reopens the bus ports of a power domain around its power transitions. Before a domain powers down, a protect request makes the block close every configured port. After the domain's SRAM has come back during power-up, an unprotect request makes it reopen them. The block holds a small table of fence entries. Each entry has a command mask, an acknowledge mask and three option bits. For each entry in turn it pulses a set or clear strobe toward the fabric, then samples the fabric's acknowledge vector at a fixed interval until the expected pattern appears.

Protect walks the table upward and ends at the first entry with an empty command mask. Unprotect walks it downward and passes over empty entries. Each entry's options can do three things: swap which strobe each direction uses, let a clear finish without any acknowledge, and make a clear wait for the acknowledge bits to read all ones rather than all zeros. The acknowledge wait has a sample budget. If the budget runs out, the walk stops at once and an error pulse is raised in place of done. Software loads the table through a write port, and the block accepts those writes only while it is idle.

Top module: `bus_fence_engine`

## Requirements
- R1: A protect request accepted while idle visits entries in rising index order starting at 0, and ends with done at the first entry whose command mask is zero; that entry and all above it get no strobe.
- R2: An unprotect request accepted while idle visits entries in falling index order starting at ENTRIES-1, passes over entries whose command mask is zero without strobing them, and ends with done after entry 0.
- R3: An entry whose inverted option is 0 receives a set strobe on protect and a clear strobe on unprotect; with the option at 1 the two are swapped.
- R4: After a set strobe the walk advances only once every bit selected by the entry's acknowledge mask reads 1 at a sample point.
- R5: After a clear strobe the masked acknowledge must read all zeros, or all ones (equal to the acknowledge mask) when the entry's all-ones option is 1.
- R6: A clear on an entry whose skip option is 1 advances right after the strobe, whatever the acknowledge input shows.
- R7: The acknowledge is sampled every POLL_INTERVAL cycles. If POLL_LIMIT samples all fail, error pulses exactly POLL_INTERVAL*POLL_LIMIT+1 cycles after the strobe, no later entry is strobed, and the block returns to idle.
- R8: Table writes take effect only while busy is low; a write issued during a walk leaves the table unchanged.
- R9: Strobes are single-cycle and at most one of them is high in any cycle. While a strobe is high, the mask output carries the entry's command mask. done and error are single-cycle pulses, never high together, and each coincides with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protectReq | input | 1 | Start a protect walk (taken when idle; wins over unprotect) |
| unprotectReq | input | 1 | Start an unprotect walk (taken when idle) |
| cfgWrEn | input | 1 | Table write enable (ignored while busy) |
| cfgIdx | input | IDX_W | Table entry to write |
| cfgSetClrMask | input | MASK_W | Command mask; zero marks an empty entry |
| cfgStaMask | input | MASK_W | Acknowledge bits this entry waits on |
| cfgInverted | input | 1 | Swap set and clear for this entry |
| cfgSkipClrAck | input | 1 | Clear finishes without waiting for acknowledge |
| cfgClrFull | input | 1 | Clear waits for all-ones instead of all-zeros |
| ackStatus | input | MASK_W | Acknowledge vector from the fabric |
| setStrobe | output | ENTRIES | One-cycle set pulse, one bit per entry |
| clrStrobe | output | ENTRIES | One-cycle clear pulse, one bit per entry |
| strobeMask | output | MASK_W | Command mask of the entry being strobed, zero otherwise |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: walk completed |
| error | output | 1 | One-cycle pulse: acknowledge wait timed out |

## Verification
The checker watches the strobe and finish signals on every cycle. It checks that strobes are single pulses, one-hot and never zero-masked, that they come only while busy, and that done and error exclude each other and arrive with busy low. It also counts cycles from each strobe so that every error lands exactly on the timeout boundary. Which entries are visited, in what order, with which strobe polarity, and whether a clear waits for zeros, for ones or for nothing depend on the table contents and on the fabric's answers. Only the bench's scenarios can show those, since its fabric model responds to strobes and can hold chosen acknowledge bits stuck.

// File: rtl/fence_pkg.sv
package fence_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PICK  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } fenceState_t;

  // per-entry options held in the table
  typedef struct packed {
    logic inverted;
    logic skipClrAck;
    logic clrFull;
  } entryFlags_t;

  // control -> datapath strobes
  typedef struct packed {
    logic startFwd;
    logic startRev;
    logic stepIdx;
    logic fireSet;
    logic fireClr;
    logic armTimer;
  } ctlCmd_t;

  // datapath -> control conditions
  typedef struct packed {
    logic maskZero;
    logic atLast;
    logic fwd;
    logic wantSet;
    logic noClrAck;
    logic pollTick;
    logic ackOk;
    logic pollsSpent;
  } dpStat_t;

endpackage

// File: rtl/fence_table.sv
module fence_table
  import fence_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int MASK_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [MASK_W-1:0] wrSetClr,
  input  logic [MASK_W-1:0] wrSta,
  input  entryFlags_t       wrFlags,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [MASK_W-1:0] rdSetClr,
  output logic [MASK_W-1:0] rdSta,
  output entryFlags_t       rdFlags
);

  logic [MASK_W-1:0] setClrQ [ENTRIES];
  logic [MASK_W-1:0] staQ    [ENTRIES];
  entryFlags_t       flagsQ  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wrEn && (wrIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        setClrQ[e] <= '0;
        staQ[e]    <= '0;
        flagsQ[e]  <= '0;
      end else if (hit) begin
        setClrQ[e] <= wrSetClr;
        staQ[e]    <= wrSta;
        flagsQ[e]  <= wrFlags;
      end
    end
  end

  assign rdSetClr = setClrQ[rdIdx];
  assign rdSta    = staQ[rdIdx];
  assign rdFlags  = flagsQ[rdIdx];

endmodule

// File: rtl/fence_datapath.sv
module fence_datapath
  import fence_pkg::*;
#(
  parameter int ENTRIES       = 6,
  parameter int MASK_W        = 8,
  parameter int IDX_W         = 3,
  parameter int POLL_INTERVAL = 4,
  parameter int POLL_LIMIT    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlCmd_t            cmd,
  input  logic [MASK_W-1:0]  ackStatus,
  input  logic [MASK_W-1:0]  rdSetClr,
  input  logic [MASK_W-1:0]  rdSta,
  input  entryFlags_t        rdFlags,
  output logic [IDX_W-1:0]   rdIdx,
  output dpStat_t            stat,
  output logic [ENTRIES-1:0] setStrobe,
  output logic [ENTRIES-1:0] clrStrobe,
  output logic [MASK_W-1:0]  strobeMask
);

  localparam int TICK_W = $clog2(POLL_INTERVAL + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(ENTRIES - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(POLL_INTERVAL - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

  logic [IDX_W-1:0]  idx;
  logic              dirFwd;
  logic              opIsSet;
  logic [TICK_W-1:0] tickCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [MASK_W-1:0] seenBits;
  logic [MASK_W-1:0] targetBits;

  // walk position and direction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx    <= '0;
      dirFwd <= 1'b1;
    end else if (cmd.startFwd) begin
      idx    <= '0;
      dirFwd <= 1'b1;
    end else if (cmd.startRev) begin
      idx    <= LAST_IDX;
      dirFwd <= 1'b0;
    end else if (cmd.stepIdx) begin
      idx <= dirFwd ? idx + 1'b1 : idx - 1'b1;
    end
  end

  // polarity of the last issued strobe
  always_ff @(posedge clk) begin
    if (!rstN)             opIsSet <= 1'b0;
    else if (cmd.fireSet)  opIsSet <= 1'b1;
    else if (cmd.fireClr)  opIsSet <= 1'b0;
  end

  // registered per-entry strobes
  for (genvar i = 0; i < ENTRIES; i++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (!rstN) begin
        setStrobe[i] <= 1'b0;
        clrStrobe[i] <= 1'b0;
      end else begin
        setStrobe[i] <= cmd.fireSet && (idx == IDX_W'(i));
        clrStrobe[i] <= cmd.fireClr && (idx == IDX_W'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          strobeMask <= '0;
    else if (cmd.fireSet || cmd.fireClr) strobeMask <= rdSetClr;
    else                                strobeMask <= '0;
  end

  // sample interval and sample budget
  always_ff @(posedge clk) begin
    if (!rstN || cmd.armTimer) begin
      tickCnt <= '0;
      pollCnt <= '0;
    end else if (tickCnt == TICK_LAST) begin
      tickCnt <= '0;
      if (pollCnt != POLL_LAST) pollCnt <= pollCnt + 1'b1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign seenBits   = ackStatus & rdSta;
  assign targetBits = (opIsSet || rdFlags.clrFull) ? rdSta : '0;

  assign rdIdx           = idx;
  assign stat.maskZero   = (rdSetClr == '0);
  assign stat.atLast     = dirFwd ? (idx == LAST_IDX) : (idx == '0);
  assign stat.fwd        = dirFwd;
  assign stat.wantSet    = dirFwd ^ rdFlags.inverted;
  assign stat.noClrAck   = !opIsSet && rdFlags.skipClrAck;
  assign stat.pollTick   = (tickCnt == TICK_LAST);
  assign stat.ackOk      = (seenBits == targetBits);
  assign stat.pollsSpent = (pollCnt == POLL_LAST);

endmodule

// File: rtl/fence_ctrl.sv
module fence_ctrl
  import fence_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    protectReq,
  input  logic    unprotectReq,
  input  dpStat_t stat,
  output ctlCmd_t cmd,
  output logic    busy,
  output logic    done,
  output logic    error
);

  fenceState_t state, nextState;
  logic doneNext, errNext;

  always_comb begin
    nextState = state;
    cmd       = '0;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (protectReq) begin
          cmd.startFwd = 1'b1;
          nextState    = ST_PICK;
        end else if (unprotectReq) begin
          cmd.startRev = 1'b1;
          nextState    = ST_PICK;
        end
      end
      ST_PICK: begin
        if (stat.maskZero) begin
          if (stat.fwd || stat.atLast) begin
            doneNext  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            cmd.stepIdx = 1'b1;
          end
        end else begin
          cmd.fireSet = stat.wantSet;
          cmd.fireClr = !stat.wantSet;
          nextState   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (stat.noClrAck) begin
          if (stat.atLast) begin
            doneNext  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            cmd.stepIdx = 1'b1;
            nextState   = ST_PICK;
          end
        end else begin
          cmd.armTimer = 1'b1;
          nextState    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stat.pollTick) begin
          if (stat.ackOk) begin
            if (stat.atLast) begin
              doneNext  = 1'b1;
              nextState = ST_IDLE;
            end else begin
              cmd.stepIdx = 1'b1;
              nextState   = ST_PICK;
            end
          end else if (stat.pollsSpent) begin
            errNext   = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneNext;
      error <= errNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/bus_fence_engine.sv
module bus_fence_engine
  import fence_pkg::*;
#(
  parameter int ENTRIES       = 6,
  parameter int MASK_W        = 8,
  parameter int POLL_INTERVAL = 4,
  parameter int POLL_LIMIT    = 8,
  localparam int IDX_W        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               protectReq,
  input  logic               unprotectReq,
  input  logic               cfgWrEn,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [MASK_W-1:0]  cfgSetClrMask,
  input  logic [MASK_W-1:0]  cfgStaMask,
  input  logic               cfgInverted,
  input  logic               cfgSkipClrAck,
  input  logic               cfgClrFull,
  input  logic [MASK_W-1:0]  ackStatus,
  output logic [ENTRIES-1:0] setStrobe,
  output logic [ENTRIES-1:0] clrStrobe,
  output logic [MASK_W-1:0]  strobeMask,
  output logic               busy,
  output logic               done,
  output logic               error
);

  ctlCmd_t           cmd;
  dpStat_t           stat;
  logic [IDX_W-1:0]  rdIdx;
  logic [MASK_W-1:0] rdSetClr;
  logic [MASK_W-1:0] rdSta;
  entryFlags_t       rdFlags;
  entryFlags_t       wrFlags;

  assign wrFlags = '{inverted: cfgInverted, skipClrAck: cfgSkipClrAck, clrFull: cfgClrFull};

  fence_table #(
    .ENTRIES(ENTRIES), .MASK_W(MASK_W), .IDX_W(IDX_W)
  ) u_table (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (cfgWrEn && !busy),
    .wrIdx    (cfgIdx),
    .wrSetClr (cfgSetClrMask),
    .wrSta    (cfgStaMask),
    .wrFlags  (wrFlags),
    .rdIdx    (rdIdx),
    .rdSetClr (rdSetClr),
    .rdSta    (rdSta),
    .rdFlags  (rdFlags)
  );

  fence_datapath #(
    .ENTRIES(ENTRIES), .MASK_W(MASK_W), .IDX_W(IDX_W),
    .POLL_INTERVAL(POLL_INTERVAL), .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .ackStatus  (ackStatus),
    .rdSetClr   (rdSetClr),
    .rdSta      (rdSta),
    .rdFlags    (rdFlags),
    .rdIdx      (rdIdx),
    .stat       (stat),
    .setStrobe  (setStrobe),
    .clrStrobe  (clrStrobe),
    .strobeMask (strobeMask)
  );

  fence_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .protectReq   (protectReq),
    .unprotectReq (unprotectReq),
    .stat         (stat),
    .cmd          (cmd),
    .busy         (busy),
    .done         (done),
    .error        (error)
  );

endmodule

// File: rtl/fence_checker.sv
module fence_checker #(
  parameter int ENTRIES       = 6,
  parameter int MASK_W        = 8,
  parameter int POLL_INTERVAL = 4,
  parameter int POLL_LIMIT    = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               protectReq,
  input logic               unprotectReq,
  input logic [ENTRIES-1:0] setStrobe,
  input logic [ENTRIES-1:0] clrStrobe,
  input logic [MASK_W-1:0]  strobeMask,
  input logic               busy,
  input logic               done,
  input logic               error
);

  localparam int WINDOW = POLL_INTERVAL * POLL_LIMIT + 1;
  localparam int SW     = $clog2(WINDOW + 2);
  localparam logic [SW-1:0] SAT = SW'(WINDOW + 1);

  logic anyStrobe;
  logic [SW-1:0] sinceStrobe;

  assign anyStrobe = (|setStrobe) || (|clrStrobe);

  always_ff @(posedge clk) begin
    if (!rstN)                    sinceStrobe <= '0;
    else if (anyStrobe)           sinceStrobe <= SW'(1);
    else if (sinceStrobe != SAT)  sinceStrobe <= sinceStrobe + 1'b1;
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setStrobe, clrStrobe})); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !anyStrobe); // R9

  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> busy); // R9

  AST_FINISH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R9

  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> !busy); // R9

  AST_NO_EMPTY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> (strobeMask != '0)); // R1

  AST_REQ_STARTS_WALK: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (protectReq || unprotectReq)) |=> busy); // R2

  AST_TIMEOUT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (sinceStrobe == SW'(WINDOW))); // R7

endmodule

bind bus_fence_engine fence_checker #(
  .ENTRIES(ENTRIES), .MASK_W(MASK_W),
  .POLL_INTERVAL(POLL_INTERVAL), .POLL_LIMIT(POLL_LIMIT)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .protectReq   (protectReq),
  .unprotectReq (unprotectReq),
  .setStrobe    (setStrobe),
  .clrStrobe    (clrStrobe),
  .strobeMask   (strobeMask),
  .busy         (busy),
  .done         (done),
  .error        (error)
);

// File: tb/sim_bus_fence_engine.sv
module sim_bus_fence_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 6;
  localparam int MASK_W = 8;
  localparam int PI = 4;
  localparam int PL = 8;
  localparam int IDX_W = 3;

  localparam logic [1:0] K_SET = 2'd0, K_CLR = 2'd1, K_DONE = 2'd2, K_ERR = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic protectReq = 1'b0, unprotectReq = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [MASK_W-1:0] cfgSetClrMask = '0, cfgStaMask = '0;
  logic cfgInverted = 1'b0, cfgSkipClrAck = 1'b0, cfgClrFull = 1'b0;
  logic [MASK_W-1:0] ackReg = '0;
  logic [MASK_W-1:0] stuckBits = '0;
  logic [ENTRIES-1:0] setStrobe, clrStrobe;
  logic [MASK_W-1:0] strobeMask;
  logic busy, done, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_fence_engine #(
    .ENTRIES(ENTRIES), .MASK_W(MASK_W), .POLL_INTERVAL(PI), .POLL_LIMIT(PL)
  ) u0 (
    .clk(clk), .rstN(rstN), .protectReq(protectReq), .unprotectReq(unprotectReq),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgSetClrMask(cfgSetClrMask),
    .cfgStaMask(cfgStaMask), .cfgInverted(cfgInverted), .cfgSkipClrAck(cfgSkipClrAck),
    .cfgClrFull(cfgClrFull), .ackStatus(ackReg), .setStrobe(setStrobe),
    .clrStrobe(clrStrobe), .strobeMask(strobeMask), .busy(busy), .done(done),
    .error(error)
  );

  // shadow of the table as the bench believes it to be
  logic [MASK_W-1:0] shSetClr [ENTRIES];
  logic [MASK_W-1:0] shSta    [ENTRIES];
  bit shInv [ENTRIES];
  bit shSkip[ENTRIES];
  bit shFull[ENTRIES];

  typedef struct packed {
    logic [1:0] kind;
    logic [2:0] ent;
    logic [7:0] mask;
  } ev_t;

  ev_t   expQ[$];
  string tagQ[$];
  int vectors = 0, miscompares = 0, cycle = 0;
  int lastStrobeCyc = 0, errCyc = 0;

  task automatic pushEv(input logic [1:0] k, input int e, input logic [7:0] m, input string tag);
    ev_t ev;
    ev.kind = k; ev.ent = 3'(e); ev.mask = m;
    expQ.push_back(ev);
    tagQ.push_back(tag);
  endtask

  task automatic observe(input logic [1:0] k, input int e, input logic [7:0] m);
    ev_t got, exp;
    string tag;
    got.kind = k; got.ent = 3'(e); got.mask = m;
    vectors++;
    if (expQ.size() == 0) begin
      miscompares++;
      $display("FAIL unexpected event: got kind/ent/mask %0d/%0d/%h expected nothing", k, e, m);
    end else begin
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      if (got != exp) begin
        miscompares++;
        $display("FAIL %s (R9 mask): got kind/ent/mask %0d/%0d/%h expected %0d/%0d/%h",
                 tag, got.kind, got.ent, got.mask, exp.kind, exp.ent, exp.mask);
      end
    end
  endtask

  // monitor and fabric model
  always @(negedge clk) begin
    logic [MASK_W-1:0] nv;
    cycle++;
    if (rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (setStrobe[i]) begin
          observe(K_SET, i, strobeMask);
          lastStrobeCyc = cycle;
          nv = ackReg | shSta[i];
          ackReg = (ackReg & stuckBits) | (nv & ~stuckBits);
        end
        if (clrStrobe[i]) begin
          observe(K_CLR, i, strobeMask);
          lastStrobeCyc = cycle;
          nv = shFull[i] ? (ackReg | shSta[i]) : (ackReg & ~shSta[i]);
          ackReg = (ackReg & stuckBits) | (nv & ~stuckBits);
        end
      end
      if (done) observe(K_DONE, 0, 8'h00);
      if (error) begin
        observe(K_ERR, 0, 8'h00);
        errCyc = cycle;
      end
    end
  end

  task automatic cfgRaw(input int e, input logic [7:0] sc, input logic [7:0] st,
                        input bit inv, input bit skip, input bit full);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = IDX_W'(e); cfgSetClrMask = sc; cfgStaMask = st;
    cfgInverted = inv; cfgSkipClrAck = skip; cfgClrFull = full;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgWrite(input int e, input logic [7:0] sc, input logic [7:0] st,
                          input bit inv, input bit skip, input bit full);
    cfgRaw(e, sc, st, inv, skip, full);
    shSetClr[e] = sc; shSta[e] = st; shInv[e] = inv; shSkip[e] = skip; shFull[e] = full;
  endtask

  task automatic pulseReq(input bit fwd);
    @(negedge clk);
    if (fwd) protectReq = 1'b1; else unprotectReq = 1'b1;
    @(negedge clk);
    protectReq = 1'b0; unprotectReq = 1'b0;
  endtask

  // expected visit list for a walk whose acknowledges all arrive
  task automatic startWalk(input bit fwd, input string tag);
    if (fwd) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (shSetClr[i] == 0) break;
        pushEv(shInv[i] ? K_CLR : K_SET, i, shSetClr[i], tag);
      end
    end else begin
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (shSetClr[i] == 0) continue;
        pushEv(shInv[i] ? K_SET : K_CLR, i, shSetClr[i], tag);
      end
    end
    pushEv(K_DONE, 0, 8'h00, tag);
    pulseReq(fwd);
  endtask

  task automatic finishWalk(input string tag);
    int n = 0;
    while (!(done || error) && n < 1000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL %s: %0d expected events missing (actual %0d left, expected 0)",
               tag, expQ.size(), expQ.size());
      expQ.delete();
      tagQ.delete();
    end
  endtask

  task automatic runWalk(input bit fwd, input string tag);
    startWalk(fwd, tag);
    finishWalk(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      shSetClr[i] = '0; shSta[i] = '0; shInv[i] = 0; shSkip[i] = 0; shFull[i] = 0;
    end
    repeat (3) @(negedge clk);
    // reset state (R9)
    vectors++;
    if (busy !== 1'b0 || done !== 1'b0 || error !== 1'b0 || setStrobe !== '0 || clrStrobe !== '0) begin
      miscompares++;
      $display("FAIL R9 reset: busy/done/error %b%b%b expected 000", busy, done, error);
    end
    rstN = 1'b1;

    // base table, entry 4 empty
    cfgWrite(0, 8'hA1, 8'h01, 0, 0, 0);
    cfgWrite(1, 8'h22, 8'h02, 0, 0, 0);
    cfgWrite(2, 8'h04, 8'h0C, 0, 0, 0);
    cfgWrite(3, 8'h08, 8'h10, 0, 0, 0);
    cfgWrite(5, 8'h40, 8'hE0, 0, 0, 0);

    runWalk(1'b1, "R1");           // forward, stops at entry 4
    runWalk(1'b0, "R2");           // reverse, skips entry 4; clears wait for zero (R5)

    // inverted entry and all-ones clear polarity
    cfgWrite(1, 8'h22, 8'h02, 1, 0, 0);
    cfgWrite(2, 8'h04, 8'h0C, 0, 0, 1);
    runWalk(1'b1, "R3");
    runWalk(1'b0, "R5");

    // skipped clear acknowledge with the status bit stuck high
    cfgWrite(3, 8'h08, 8'h10, 0, 1, 0);
    @(negedge clk);
    stuckBits = 8'h10; ackReg = ackReg | 8'h10;
    runWalk(1'b0, "R6");
    cfgWrite(3, 8'h08, 8'h10, 0, 0, 0);

    // timeout: entry 2 acknowledge never rises
    @(negedge clk);
    stuckBits = 8'h0C; ackReg = ackReg & ~8'h0C;
    pushEv(K_SET, 0, 8'hA1, "R7");
    pushEv(K_CLR, 1, 8'h22, "R7");
    pushEv(K_SET, 2, 8'h04, "R7");
    pushEv(K_ERR, 0, 8'h00, "R7");
    pulseReq(1'b1);
    finishWalk("R7");
    vectors++;
    if (errCyc - lastStrobeCyc != PI * PL + 1) begin
      miscompares++;
      $display("FAIL R7 timeout delay: actual %0d expected %0d", errCyc - lastStrobeCyc, PI * PL + 1);
    end

    // partial acknowledge: only one of two bits rises
    @(negedge clk);
    stuckBits = 8'h08; ackReg = ackReg & ~8'h08;
    pushEv(K_SET, 0, 8'hA1, "R4");
    pushEv(K_CLR, 1, 8'h22, "R4");
    pushEv(K_SET, 2, 8'h04, "R4");
    pushEv(K_ERR, 0, 8'h00, "R4");
    pulseReq(1'b1);
    finishWalk("R4");

    // write during a walk is dropped, write while idle lands
    @(negedge clk);
    stuckBits = 8'h00;
    startWalk(1'b1, "R8");
    cfgRaw(3, 8'h00, 8'h10, 0, 0, 0);
    finishWalk("R8");
    cfgWrite(3, 8'h00, 8'h10, 0, 0, 0);
    runWalk(1'b1, "R8");

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule